// File: doc/BRIEF.md
# Combined Divide and Remainder Unit

This block is a multi-cycle unsigned integer divider that returns both the quotient and the remainder of one division. A single start pulse hands it a dividend, a divisor and two destination register indices, one for each result. The unit captures all of these on the accepting clock edge. It then runs a restoring division that settles one quotient bit per cycle. At the end it presents both results, each tagged with its destination index and a write enable, during a one-cycle done pulse.

A zero divisor never hangs the unit. The unit skips the iteration, loads all ones into both results and raises done on the next cycle. Register index 0 is a hard-wired zero register, so the unit never asserts a write enable for a result aimed at it. The unit is meant to sit beside an execution pipeline. The pipeline issues the combined divide/remainder operation and drains the two tagged results into its register file.

Top module: `divrem_unit`

## Requirements
- R1: For a non-zero divisor, `quotient_o` equals the unsigned integer quotient `dividend / divisor` while `done_o` is high.
- R2: For a non-zero divisor, `remainder_o` equals `dividend % divisor`, and so is strictly below the divisor, while `done_o` is high.
- R3: For a zero divisor, `quotient_o` and `remainder_o` are both all ones, and `done_o` is high in the cycle right after the accepting edge.
- R4: `done_o` is a single-cycle pulse. `busy_o` is high from the accepting edge through the done cycle, and low in the cycle after done.
- R5: A `start_i` pulse that arrives while `busy_o` is high is ignored and changes neither the results, the tags nor the timing.
- R6: Operands and destination indices are captured on the accepting edge, so later changes on `dividend_i`, `divisor_i`, `q_idx_i` and `r_idx_i` do not affect the pending result.
- R7: `q_idx_o`/`r_idx_o` carry the captured destinations. `q_we_o` (resp. `r_we_o`) is high only during `done_o` and only when its destination index is non-zero.
- R8: After reset `busy_o`, `done_o`, `q_we_o` and `r_we_o` are low.
- R9: For a non-zero divisor, `done_o` goes high after exactly DATA_W rising edges following the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, accepted when not busy |
| dividend_i | input | DATA_W | Dividend |
| divisor_i | input | DATA_W | Divisor |
| q_idx_i | input | IDX_W | Destination index for the quotient |
| r_idx_i | input | IDX_W | Destination index for the remainder |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle result-valid pulse |
| quotient_o | output | DATA_W | Quotient |
| remainder_o | output | DATA_W | Remainder |
| q_idx_o | output | IDX_W | Captured quotient destination |
| r_idx_o | output | IDX_W | Captured remainder destination |
| q_we_o | output | 1 | Quotient write enable |
| r_we_o | output | 1 | Remainder write enable |

## Verification
The bound checker watches several properties on every cycle. It checks that done is a single pulse inside the busy window, and that write enables appear only with done and a non-zero tag. It checks the early all-ones result on a zero divisor and that tags stay stable while busy. It checks that the remainder stays below the captured divisor, and it counts the exact latency. Only the bench scenarios can show that the quotient and remainder values are arithmetically right. The bench sweeps every operand pair of a 6-bit instance and runs directed 64-bit corners. It also shows that mid-operation input changes and repeated start pulses leave the result untouched.

// File: rtl/divrem_pkg.sv
package divrem_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } divrem_state_e;

  localparam int unsigned NUM_WB = 2;  // quotient port, remainder port
  localparam int unsigned WB_QUO = 0;
  localparam int unsigned WB_REM = 1;
endpackage

// File: rtl/divrem_step.sv
// One restoring iteration: shift in the next dividend bit, trial-subtract.
module divrem_step #(
  parameter int unsigned DATA_W = 64
) (
  input  logic [DATA_W-1:0] rem_i,
  input  logic [DATA_W-1:0] quo_i,
  input  logic [DATA_W-1:0] dvs_i,
  output logic [DATA_W-1:0] rem_o,
  output logic [DATA_W-1:0] quo_o
);
  logic [DATA_W:0] shifted;
  logic [DATA_W:0] diff;

  always_comb begin
    shifted = {rem_i, quo_i[DATA_W-1]};
    diff    = shifted - {1'b0, dvs_i};
    rem_o   = diff[DATA_W] ? shifted[DATA_W-1:0] : diff[DATA_W-1:0];
    quo_o   = {quo_i[DATA_W-2:0], ~diff[DATA_W]};
  end
endmodule

// File: rtl/divrem_ctrl.sv
module divrem_ctrl
  import divrem_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          div_zero_i,
  output logic          accept_o,
  output logic          step_o,
  output divrem_state_e state_o
);
  localparam int unsigned CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  divrem_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    accept_o = 1'b0;
    step_o   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        accept_o = 1'b1;
        cnt_d    = '0;
        state_d  = div_zero_i ? ST_DONE : ST_RUN;
      end
      ST_RUN: begin
        step_o = 1'b1;
        cnt_d  = cnt_q + 1'b1;
        if (cnt_q == LAST) state_d = ST_DONE;
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/divrem_unit.sv
module divrem_unit
  import divrem_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned IDX_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] dividend_i,
  input  logic [DATA_W-1:0] divisor_i,
  input  logic [IDX_W-1:0]  q_idx_i,
  input  logic [IDX_W-1:0]  r_idx_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] quotient_o,
  output logic [DATA_W-1:0] remainder_o,
  output logic [IDX_W-1:0]  q_idx_o,
  output logic [IDX_W-1:0]  r_idx_o,
  output logic              q_we_o,
  output logic              r_we_o
);
  divrem_state_e state;
  logic accept, step;
  logic div_zero;
  logic [DATA_W-1:0] quo_q, rem_q, dvs_q;
  logic [DATA_W-1:0] quo_nx, rem_nx;
  logic [NUM_WB-1:0][IDX_W-1:0] dst_q;
  logic [NUM_WB-1:0] we;

  assign div_zero = (divisor_i == '0);

  divrem_ctrl #(.DATA_W(DATA_W)) ctrl_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .div_zero_i (div_zero),
    .accept_o   (accept),
    .step_o     (step),
    .state_o    (state)
  );

  divrem_step #(.DATA_W(DATA_W)) step_i (
    .rem_i (rem_q),
    .quo_i (quo_q),
    .dvs_i (dvs_q),
    .rem_o (rem_nx),
    .quo_o (quo_nx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      quo_q <= '0;
      rem_q <= '0;
      dvs_q <= '0;
      dst_q <= '0;
    end else if (accept) begin
      dvs_q          <= divisor_i;
      dst_q[WB_QUO]  <= q_idx_i;
      dst_q[WB_REM]  <= r_idx_i;
      // zero divisor: defined all-ones result, no iteration
      quo_q <= div_zero ? '1 : dividend_i;
      rem_q <= div_zero ? '1 : '0;
    end else if (step) begin
      quo_q <= quo_nx;
      rem_q <= rem_nx;
    end
  end

  assign busy_o = (state != ST_IDLE);
  assign done_o = (state == ST_DONE);

  // index 0 is the zero register: suppress its write
  for (genvar p = 0; p < NUM_WB; p++) begin : g_wb
    assign we[p] = done_o && (dst_q[p] != '0);
  end

  assign quotient_o  = quo_q;
  assign remainder_o = rem_q;
  assign q_idx_o     = dst_q[WB_QUO];
  assign r_idx_o     = dst_q[WB_REM];
  assign q_we_o      = we[WB_QUO];
  assign r_we_o      = we[WB_REM];
endmodule

// File: rtl/divrem_chk.sv
module divrem_chk #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned IDX_W  = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [DATA_W-1:0] divisor_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [DATA_W-1:0] quotient_o,
  input logic [DATA_W-1:0] remainder_o,
  input logic [IDX_W-1:0]  q_idx_o,
  input logic [IDX_W-1:0]  r_idx_o,
  input logic              q_we_o,
  input logic              r_we_o
);
  localparam int unsigned LW = $clog2(DATA_W + 1) + 1;

  logic [LW-1:0]     lat_q;
  logic              zf_q;
  logic [DATA_W-1:0] dvs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q <= '0;
      zf_q  <= 1'b0;
      dvs_q <= '0;
    end else if (start_i && !busy_o) begin
      lat_q <= '0;
      zf_q  <= (divisor_i == '0);
      dvs_q <= divisor_i;
    end else if (busy_o && !done_o) begin
      lat_q <= lat_q + 1'b1;
    end
  end

  // R4
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R4
  done_in_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);
  // R4
  busy_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
  // R7
  q_we_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_we_o |-> (done_o && q_idx_o != '0));
  // R7
  r_we_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    r_we_o |-> (done_o && r_idx_o != '0));
  // R3
  zero_div_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && divisor_i == '0) |=>
      (done_o && quotient_o == '1 && remainder_o == '1));
  // R5
  tag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ($stable(q_idx_o) && $stable(r_idx_o)));
  // R9
  latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (zf_q ? (lat_q == '0) : (lat_q == LW'(DATA_W))));
  // R2
  rem_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !zf_q) |-> (remainder_o < dvs_q));
endmodule

bind divrem_unit divrem_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .divisor_i   (divisor_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .quotient_o  (quotient_o),
  .remainder_o (remainder_o),
  .q_idx_o     (q_idx_o),
  .r_idx_o     (r_idx_o),
  .q_we_o      (q_we_o),
  .r_we_o      (r_we_o)
);

// File: tb/divrem_unit_tb_top.sv
`timescale 1ns/1ps
module divrem_unit_tb_top;
  localparam int SW = 6;
  localparam int IW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;

  // small instance, swept exhaustively
  logic          s_start = 1'b0;
  logic [SW-1:0] s_a = '0, s_b = '0;
  logic [IW-1:0] s_qi = '0, s_ri = '0;
  logic          s_busy, s_done, s_qwe, s_rwe;
  logic [SW-1:0] s_q, s_r;
  logic [IW-1:0] s_qo, s_ro;

  divrem_unit #(.DATA_W(SW), .IDX_W(IW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(s_start),
    .dividend_i(s_a), .divisor_i(s_b), .q_idx_i(s_qi), .r_idx_i(s_ri),
    .busy_o(s_busy), .done_o(s_done), .quotient_o(s_q), .remainder_o(s_r),
    .q_idx_o(s_qo), .r_idx_o(s_ro), .q_we_o(s_qwe), .r_we_o(s_rwe));

  // full-width instance, directed corners
  logic          w_start = 1'b0;
  logic [63:0]   w_a = '0, w_b = '0;
  logic [IW-1:0] w_qi = '0, w_ri = '0;
  logic          w_busy, w_done, w_qwe, w_rwe;
  logic [63:0]   w_q, w_r;
  logic [IW-1:0] w_qo, w_ro;

  divrem_unit #(.DATA_W(64), .IDX_W(IW)) dut64_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(w_start),
    .dividend_i(w_a), .divisor_i(w_b), .q_idx_i(w_qi), .r_idx_i(w_ri),
    .busy_o(w_busy), .done_o(w_done), .quotient_o(w_q), .remainder_o(w_r),
    .q_idx_o(w_qo), .r_idx_o(w_ro), .q_we_o(w_qwe), .r_we_o(w_rwe));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_small(input logic [SW-1:0] a, input logic [SW-1:0] b,
                           input logic [IW-1:0] qi, input logic [IW-1:0] ri,
                           input bit disturb);
    logic [SW-1:0] eq, er;
    int lat, elat;
    @(negedge clk);
    s_start = 1'b1; s_a = a; s_b = b; s_qi = qi; s_ri = ri;
    @(posedge clk); #1;
    s_start = 1'b0;
    if (disturb) begin  // R6: inputs change after accept
      s_a = ~a; s_b = b ^ 6'h2b; s_qi = ~qi; s_ri = qi;
    end
    lat = 0;
    while (!s_done && lat < 200) begin
      s_start = disturb && (lat == 2);  // R5: start while busy
      @(posedge clk); #1;
      lat++;
    end
    s_start = 1'b0;
    if (b == 0) begin eq = '1; er = '1; elat = 0; end
    else begin eq = a / b; er = a % b; elat = SW; end
    chk(s_q == eq, (b == 0) ? "R3" : "R1", "quotient", 64'(s_q), 64'(eq));
    chk(s_r == er, (b == 0) ? "R3" : "R2", "remainder", 64'(s_r), 64'(er));
    chk(lat == elat, (b == 0) ? "R3" : "R9", "latency", 64'(lat), 64'(elat));
    chk(s_busy, "R4", "busy at done", 64'(s_busy), 64'd1);
    chk(s_qo == qi && s_ro == ri, "R6", "tags", {s_qo, s_ro}, {qi, ri});
    chk(s_qwe == (qi != 0), "R7", "q_we", 64'(s_qwe), 64'(qi != 0));
    chk(s_rwe == (ri != 0), "R7", "r_we", 64'(s_rwe), 64'(ri != 0));
    @(posedge clk); #1;
    chk(!s_done && !s_busy, "R4", "release after done", {s_done, s_busy}, 64'd0);
    if (disturb)  // R5: the ignored start must not have launched a new run
      chk(!s_busy, "R5", "no relaunch", 64'(s_busy), 64'd0);
  endtask

  task automatic run_wide(input logic [63:0] a, input logic [63:0] b,
                          input logic [IW-1:0] qi, input logic [IW-1:0] ri);
    logic [63:0] eq, er;
    int lat;
    @(negedge clk);
    w_start = 1'b1; w_a = a; w_b = b; w_qi = qi; w_ri = ri;
    @(posedge clk); #1;
    w_start = 1'b0; w_a = ~a; w_b = b + 64'd7;
    lat = 0;
    while (!w_done && lat < 300) begin @(posedge clk); #1; lat++; end
    if (b == 0) begin eq = '1; er = '1; end
    else begin eq = a / b; er = a % b; end
    chk(w_q == eq, (b == 0) ? "R3" : "R1", "wide quotient", w_q, eq);
    chk(w_r == er, (b == 0) ? "R3" : "R2", "wide remainder", w_r, er);
    chk(lat == ((b == 0) ? 0 : 64), "R9", "wide latency", 64'(lat),
        (b == 0) ? 64'd0 : 64'd64);
    chk(w_qwe == (qi != 0) && w_rwe == (ri != 0), "R7", "wide we",
        {w_qwe, w_rwe}, {(qi != 0), (ri != 0)});
    @(posedge clk); #1;
  endtask

  initial begin
    #(10 * 200000);
    fails++;
    $display("FAIL watchdog: actual=expired expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #3;
    // R8 reset state
    chk(!s_busy && !s_done && !s_qwe && !s_rwe, "R8", "reset small",
        {s_busy, s_done, s_qwe, s_rwe}, 64'd0);
    chk(!w_busy && !w_done && !w_qwe && !w_rwe, "R8", "reset wide",
        {w_busy, w_done, w_qwe, w_rwe}, 64'd0);
    #20 rst_n = 1'b1;

    // exhaustive sweep of the small instance, including index 0 targets
    for (int a = 0; a < (1 << SW); a++) begin
      for (int b = 0; b < (1 << SW); b++) begin
        run_small(SW'(a), SW'(b), IW'((a + b) % 4), IW'(b % 3),
                  ((a ^ b) & 5) == 1);
      end
    end

    run_wide(64'hFFFF_FFFF_FFFF_FFFF, 64'd3, 6'd1, 6'd2);
    run_wide(64'h8000_0000_0000_0001, 64'd1, 6'd5, 6'd0);
    run_wide(64'h1234_5678_9ABC_DEF0, 64'd0, 6'd0, 6'd9);
    run_wide(64'd17, 64'hFFFF_FFFF_FFFF_FFF0, 6'd3, 6'd4);
    run_wide(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFE, 6'd59, 6'd58);
    run_wide(64'hDEAD_BEEF_CAFE_F00D, 64'h0000_0001_0000_0003, 6'd7, 6'd8);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule